// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block is a memory-mapped general-purpose I/O controller. Pins are grouped into banks of 32, and pin `i` belongs to bank `i / 32` at bit `i mod 32`. Each bank has its own set of registers:

- a synchronized level readback
- a direction register
- write-one-to-set and write-one-to-clear output strobes
- rising and falling edge enables
- an edge-pass mask
- a sticky edge status that is cleared by writing ones

A single register port reaches every bank. The banks are interleaved three to a 256-byte page, so each register of three neighbouring banks sits in three consecutive words.

Edges are found on the synchronized pin value. Edges that are enabled and pass the mask are latched into the status register. Three interrupt lines come from the latched status:

- two dedicated lines that follow the status bits of pins 0 and 1
- one combined line that is high while any status bit in any bank is set

A build-time mask swaps the meaning of the direction bit for chosen pins.

Top module: `gpio_banked`

## Requirements
- R1: Reset state. Every pin is an input (`pin_oe` low), every output latch is low, edge enables, edge masks and status are zero, and all interrupts are low.
- R2: Address map. Bank `n` has its base at `((n / 3) << 8) + ((n mod 3) << 2)`. The register offsets from that base are:

  | Register | Offset |
  |---|---|
  | level | 0x00 |
  | direction | 0x0C |
  | set | 0x18 |
  | clear | 0x24 |
  | rising enable | 0x30 |
  | falling enable | 0x3C |
  | status | 0x48 |
  | edge mask | 0x9C |

  Direction, rising enable, falling enable and edge mask read back what was written.
- R3: Output strobes. A write to the set register drives high every pin whose data bit is 1. A write to the clear register drives low every pin whose data bit is 1. Bits written as 0 leave their pins unchanged. Both strobe registers read as zero.
- R4: Direction. `pin_oe = dir XOR INV_MASK`, so a direction bit of 1 means output except on inverted pins. At reset the direction register holds the `INV_MASK` bits, so every pin starts as an input.
- R5: Level. The level register returns each pin through a two-flop synchronizer, whatever the pin's direction. Writes to the level register are ignored.
- R6: Edge capture. A status bit is set on a rising edge when its rising enable is 1, or on a falling edge when its falling enable is 1. In both cases its edge-mask bit must be 1. The bit is set on the third rising clock edge after the pin changes.
- R7: Status clear. Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. With no such write, a set status bit stays set.
- R8: Collision. If an edge is captured in the same cycle as a write-one-to-clear of that bit, the bit stays set.
- R9: Interrupts. `irq_pin0` and `irq_pin1` follow the status bits of pins 0 and 1. `irq_mux` is high while any status bit in any bank is set.
- R10: Reads from an unmapped offset, or from a bank index not below `NUM_BANKS`, return zero. Writes to such addresses change no state.
- R11: Read timing. `rdata` is registered. It holds the addressed value in the cycle after `rd_en` and is zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Read data, one cycle after `rd_en` |
| pin_in | input | NUM_BANKS*32 | Pin input levels |
| pin_out | output | NUM_BANKS*32 | Output latch values |
| pin_oe | output | NUM_BANKS*32 | Output enables |
| irq_pin0 | output | 1 | Status of pin 0 |
| irq_pin1 | output | 1 | Status of pin 1 |
| irq_mux | output | 1 | Any status bit set |

## Verification
The status register has two writers that can act in the same cycle: the edge-capture path, which sets bits, and the write-one-to-clear path driven from the register port. The bench first latches a rising edge on pin 1. It then drops the pin and times a clear write to pin 1's status bit so that it lands on the exact clock edge where the falling edge is captured, which is the third edge after the pin change. The status read back afterwards must still show the bit, and a later clear with no edge in flight must remove it.

// File: rtl/gpio_banked_pkg.sv
package gpio_banked_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [3:0] {
        RK_LEVEL,
        RK_DIR,
        RK_SET,
        RK_CLR,
        RK_RISE,
        RK_FALL,
        RK_STAT,
        RK_EMASK,
        RK_NONE
    } reg_kind_e;

    typedef struct packed {
        logic      hit;
        reg_kind_e kind;
        logic [9:0] bank;
    } reg_sel_t;

    // Register group index = word offset / 3; group 13 is the edge mask.
    function automatic reg_kind_e kind_of(input logic [4:0] grp);
        case (grp)
            5'd0:    return RK_LEVEL;
            5'd1:    return RK_DIR;
            5'd2:    return RK_SET;
            5'd3:    return RK_CLR;
            5'd4:    return RK_RISE;
            5'd5:    return RK_FALL;
            5'd6:    return RK_STAT;
            5'd13:   return RK_EMASK;
            default: return RK_NONE;
        endcase
    endfunction

    // page = addr[..:8], lo = addr[7:0]; three banks share a page, one word apart.
    function automatic reg_sel_t decode_addr(input logic [7:0] page,
                                             input logic [7:0] lo,
                                             input int num_banks);
        reg_sel_t   s;
        logic [5:0] word;
        logic [4:0] grp;
        logic [1:0] slot;
        word   = lo[7:2];
        grp    = 5'(word / 6'd3);
        slot   = 2'(word % 6'd3);
        s.kind = kind_of(grp);
        s.bank = 10'(page) * 10'd3 + 10'(slot);
        s.hit  = (lo[1:0] == 2'b00) && (s.kind != RK_NONE)
              && (s.bank < 10'(num_banks));
        return s;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] prev
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            cur    <= '0;
            prev   <= '0;
        end else begin
            stage1 <= async_in;
            cur    <= stage1;
            prev   <= cur;
        end
    end
endmodule

// File: rtl/gpio_edge.sv
module gpio_edge #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] prev,
    input  logic [WIDTH-1:0] rise_en,
    input  logic [WIDTH-1:0] fall_en,
    input  logic [WIDTH-1:0] pass_mask,
    output logic [WIDTH-1:0] hit
);
    logic [WIDTH-1:0] rose, fell;

    always_comb begin
        rose = cur & ~prev;
        fell = ~cur & prev;
        hit  = ((rose & rise_en) | (fell & fall_en)) & pass_mask;
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_banked_pkg::*;
#(
    parameter logic [WORD_W-1:0] INV = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  reg_kind_e         kind,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] pin_in,
    output logic [WORD_W-1:0] rd_word,
    output logic [WORD_W-1:0] pin_out,
    output logic [WORD_W-1:0] pin_oe,
    output logic [WORD_W-1:0] status
);
    logic [WORD_W-1:0] lvl_cur, lvl_prev;
    logic [WORD_W-1:0] dir_q, rise_q, fall_q, emask_q;
    logic [WORD_W-1:0] edge_hit, clr_bits;
    logic              stat_wr;

    gpio_sync #(.WIDTH(WORD_W)) u_sync (
        .clk(clk), .rst(rst), .async_in(pin_in), .cur(lvl_cur), .prev(lvl_prev)
    );

    gpio_edge #(.WIDTH(WORD_W)) u_edge (
        .cur(lvl_cur), .prev(lvl_prev), .rise_en(rise_q), .fall_en(fall_q),
        .pass_mask(emask_q), .hit(edge_hit)
    );

    assign stat_wr  = we && (kind == RK_STAT);
    assign clr_bits = stat_wr ? wdata : '0;
    assign pin_oe   = dir_q ^ INV;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q   <= INV;
            pin_out <= '0;
            rise_q  <= '0;
            fall_q  <= '0;
            emask_q <= '0;
            status  <= '0;
        end else begin
            if (we) begin
                case (kind)
                    RK_DIR:   dir_q   <= wdata;
                    RK_SET:   pin_out <= pin_out | wdata;
                    RK_CLR:   pin_out <= pin_out & ~wdata;
                    RK_RISE:  rise_q  <= wdata;
                    RK_FALL:  fall_q  <= wdata;
                    RK_EMASK: emask_q <= wdata;
                    default:  ;
                endcase
            end
            status <= (status & ~clr_bits) | edge_hit;
        end
    end

    always_comb begin
        case (kind)
            RK_LEVEL: rd_word = lvl_cur;
            RK_DIR:   rd_word = dir_q;
            RK_RISE:  rd_word = rise_q;
            RK_FALL:  rd_word = fall_q;
            RK_STAT:  rd_word = status;
            RK_EMASK: rd_word = emask_q;
            default:  rd_word = '0;
        endcase
    end

    a_r3_set_drives_high: assert property (@(posedge clk) disable iff (rst)
        (we && kind == RK_SET) |=> (($past(wdata) & ~pin_out) == '0));

    a_r3_clear_drives_low: assert property (@(posedge clk) disable iff (rst)
        (we && kind == RK_CLR) |=> (($past(wdata) & pin_out) == '0));

    a_r6_capture_lands: assert property (@(posedge clk) disable iff (rst)
        (|edge_hit) |=> (($past(edge_hit) & ~status) == '0));

    a_r7_clear_without_edge: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && ((edge_hit & wdata) == '0)) |=> ((status & $past(wdata)) == '0));

    a_r7_sticky_status: assert property (@(posedge clk) disable iff (rst)
        !stat_wr |=> (($past(status) & ~status) == '0));
endmodule

// File: rtl/gpio_banked.sv
module gpio_banked
    import gpio_banked_pkg::*;
#(
    parameter int NUM_BANKS = 7,
    parameter int ADDR_W    = 10,
    parameter logic [NUM_BANKS*32-1:0] INV_MASK = '0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [31:0]              wdata,
    input  logic                     wr_en,
    input  logic                     rd_en,
    output logic [31:0]              rdata,
    input  logic [NUM_BANKS*32-1:0]  pin_in,
    output logic [NUM_BANKS*32-1:0]  pin_out,
    output logic [NUM_BANKS*32-1:0]  pin_oe,
    output logic                     irq_pin0,
    output logic                     irq_pin1,
    output logic                     irq_mux
);
    localparam int NPINS = NUM_BANKS * WORD_W;

    logic [7:0]         page;
    reg_sel_t           sel;
    logic [WORD_W-1:0]  bank_rd [NUM_BANKS];
    logic [NPINS-1:0]   status_all;
    logic [WORD_W-1:0]  rd_mux;

    assign page = 8'(addr[ADDR_W-1:8]);
    assign sel  = decode_addr(page, addr[7:0], NUM_BANKS);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic bank_we;
        assign bank_we = wr_en && sel.hit && (sel.bank == 10'(b));
        gpio_bank #(.INV(INV_MASK[b*WORD_W +: WORD_W])) u_bank (
            .clk(clk), .rst(rst), .we(bank_we), .kind(sel.kind), .wdata(wdata),
            .pin_in(pin_in[b*WORD_W +: WORD_W]), .rd_word(bank_rd[b]),
            .pin_out(pin_out[b*WORD_W +: WORD_W]), .pin_oe(pin_oe[b*WORD_W +: WORD_W]),
            .status(status_all[b*WORD_W +: WORD_W])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (sel.bank == 10'(b)) rd_mux = bank_rd[b];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= (rd_en && sel.hit) ? rd_mux : '0;
    end

    assign irq_pin0 = status_all[0];
    assign irq_pin1 = status_all[1];
    assign irq_mux  = |status_all;

    a_r11_idle_read_zero: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (rdata == '0));

    a_r10_miss_read_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !sel.hit) |=> (rdata == '0));

    a_r9_pin_irq_in_mux: assert property (@(posedge clk) disable iff (rst)
        (irq_pin0 || irq_pin1) |-> irq_mux);
endmodule

// File: tb/tb_gpio_banked.sv
`timescale 1ns/1ps
module tb_gpio_banked;
    localparam int NB = 7;
    localparam int NP = NB * 32;
    localparam logic [NP-1:0] INV = NP'(1) << 35;

    logic          clk = 0;
    logic          rst = 1;
    logic [9:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic          wr_en = 0, rd_en = 0;
    logic [31:0]   rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;
    logic          irq_pin0, irq_pin1, irq_mux;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    gpio_banked #(.NUM_BANKS(NB), .ADDR_W(10), .INV_MASK(INV)) dut (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq_pin0(irq_pin0), .irq_pin1(irq_pin1), .irq_mux(irq_mux)
    );

    // {addr, write data, expected read-back}
    localparam int NV = 9;
    localparam logic [73:0] VEC [NV] = '{
        {10'h00C, 32'h0000_00F0, 32'h0000_00F0},  // R2 bank0 direction
        {10'h010, 32'h0000_0000, 32'h0000_0000},  // R4 bank1 direction raw
        {10'h134, 32'hA5A5_0000, 32'hA5A5_0000},  // R2 bank4 rising enable
        {10'h23C, 32'h1234_5678, 32'h1234_5678},  // R2 bank6 falling enable
        {10'h1A4, 32'hFFFF_FFFF, 32'hFFFF_FFFF},  // R2 bank5 edge mask
        {10'h008, 32'h0000_FFFF, 32'h0000_0000},  // R5 level is read-only
        {10'h054, 32'hFFFF_FFFF, 32'h0000_0000},  // R10 unmapped offset
        {10'h210, 32'hFFFF_FFFF, 32'h0000_0000},  // R10 bank 7 absent
        {10'h118, 32'hFFFF_FFFF, 32'h0000_0000}   // R3 set strobe reads zero
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1;
        @(negedge clk);
        rd_en = 0;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst = 0;
        idle(1);

        // R1 reset state
        check("R1 oe", pin_oe[31:0] | pin_oe[63:32] | pin_oe[223:192], 32'h0);
        check("R1 out", pin_out[31:0] | pin_out[127:96], 32'h0);
        check("R1 irq", {29'h0, irq_pin0, irq_pin1, irq_mux}, 32'h0);
        rd(10'h048, v); check("R1 status", v, 32'h0);
        rd(10'h010, v); check("R4 reset dir holds inverted bits", v, 32'h0000_0008);

        // R2 table
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][73:64], VEC[i][63:32]);
            rd(VEC[i][73:64], v);
            check($sformatf("R2 table entry %0d", i), v, VEC[i][31:0]);
        end
        check("R11 rdata zero after read", rdata, 32'h0);
        check("R4 bank0 oe", pin_oe[31:0], 32'h0000_00F0);
        check("R4 inverted pin oe", pin_oe[63:32], 32'h0000_0008);
        check("R3 bank3 all set", pin_out[127:96], 32'hFFFF_FFFF);
        rd(10'h20C, v); check("R10 bank6 dir untouched", v, 32'h0);

        // R3 set and clear strobes
        wr(10'h018, 32'h0000_0F0F);
        check("R3 set", pin_out[31:0], 32'h0000_0F0F);
        wr(10'h024, 32'h0000_0303);
        check("R3 clear", pin_out[31:0], 32'h0000_0C0C);
        wr(10'h218, 32'h8000_0001);
        check("R3 bank6 set", pin_out[223:192], 32'h8000_0001);
        check("R3 bank0 unchanged", pin_out[31:0], 32'h0000_0C0C);

        // R5 level readback
        pin_in[127:96] = 32'hDEAD_BEEF;
        pin_in[7:0] = 8'hA0;
        idle(4);
        rd(10'h100, v); check("R5 bank3 level", v, 32'hDEAD_BEEF);
        rd(10'h000, v); check("R5 level of output pins", v, 32'h0000_00A0);
        rd(10'h048, v); check("R6 no capture when disabled", v, 32'h0);

        // R6 rising capture with mask
        wr(10'h030, 32'h0000_0011);
        wr(10'h09C, 32'h0000_0001);
        pin_in[0] = 1; pin_in[4] = 1;
        idle(5);
        rd(10'h048, v); check("R6 rising masked", v, 32'h0000_0001);
        check("R9 irq lines", {29'h0, irq_pin0, irq_pin1, irq_mux}, 32'h5);

        // R7 write-one-to-clear
        wr(10'h048, 32'h0);
        rd(10'h048, v); check("R7 zero write keeps", v, 32'h1);
        wr(10'h048, 32'h1);
        rd(10'h048, v); check("R7 one write clears", v, 32'h0);
        check("R9 mux low", {31'h0, irq_mux}, 32'h0);

        // R6 falling capture on bank4 pin 130
        wr(10'h140, 32'h0000_0004);
        wr(10'h1A0, 32'h0000_0004);
        pin_in[130] = 1;
        idle(5);
        rd(10'h14C, v); check("R6 rise ignored with fall enable", v, 32'h0);
        pin_in[130] = 0;
        idle(5);
        rd(10'h14C, v); check("R6 falling capture", v, 32'h4);
        check("R9 mux from bank4", {30'h0, irq_pin0, irq_mux}, 32'h1);
        wr(10'h14C, 32'h4);

        // R8 collision of edge capture and clear on pin 1
        wr(10'h030, 32'h0000_0013);
        wr(10'h03C, 32'h0000_0002);
        wr(10'h09C, 32'h0000_0003);
        pin_in[1] = 1;
        idle(5);
        rd(10'h048, v); check("R6 pin1 rising", v, 32'h2);
        check("R9 irq_pin1", {31'h0, irq_pin1}, 32'h1);
        @(negedge clk);
        pin_in[1] = 0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        addr = 10'h048; wdata = 32'h2; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
        rd(10'h048, v); check("R8 collision keeps bit", v, 32'h2);
        wr(10'h048, 32'h2);
        rd(10'h048, v); check("R7 clear after collision", v, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule